// File: doc/BRIEF.md
# Jumping Window Decode Scheduler

This controller sequences the soft decoders of a window decoder for a spatially coupled, serially concatenated code stream. It does no soft arithmetic. It emits a stream of commands. Each command names a code block and says whether the inner or the outer soft decoder works on that block. The window covers W consecutive blocks that start at the window base. In one iteration, every block in the window goes through the inner decoder in ascending order, and then every block goes through the outer decoder in the same order.

The window does not slide by one block at a time. It jumps by W/4 blocks, after a fixed Ieff/4 iterations at each position, so the number of iterations per position does not depend on the window size or the block length. When W is 4, the jump is one block and the schedule is the same as ordinary sliding window decoding. Before each jump, the controller strobes the indices of the blocks that leave the window, so that their hard decisions can be taken. It also reports the jump distance in bits, (W/4)·K. With this schedule, latency stays at K·W bits, and the coupling memory normally paired with window W is W/2 − 1.

A start pulse loads W, K and Ieff while the controller is idle. An illegal configuration is refused and flagged. After a legal start, the schedule runs without end until reset.

Top module: `jw_sched`

## Requirements
- R1: During and after reset, cmd_valid and rel_valid are low, win_base is 0 and cfg_err is low.
- R2: A start in idle with W that is not a power of two, W below 4, W above WMAX, Ieff of zero or Ieff not a multiple of 4 sets cfg_err. No command is issued afterwards. A later legal start clears cfg_err and begins the schedule.
- R3: Within an iteration, commands name blocks win_base … win_base+W−1 in ascending order with cmd_outer=0 (inner), then the same blocks in the same order with cmd_outer=1 (outer).
- R4: Exactly Ieff/4 iterations are issued at each window position before the window moves.
- R5: In the cycle after the last command of a position is accepted, rel_valid goes high for W/4 consecutive cycles. rel_blk counts up by one from win_base, and no command is valid during these cycles.
- R6: After the release cycles, win_base has grown by W/4 blocks (one block when W=4), and the next command is valid immediately.
- R7: From the cycle after a legal start, step_bits equals (W/4)·K.
- R8: While cmd_valid is high and cmd_ready is low, the command stays valid and unchanged, and no block is skipped.
- R9: A start pulse while the schedule runs is ignored: the sequence, step_bits and cfg_err are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and begin (idle only) |
| cfg_win | input | WW | Window size W in blocks |
| cfg_blklen | input | KW | Block length K in bits |
| cfg_ieff | input | IW | Effective iteration count Ieff |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_blk | output | BW | Block index of the command |
| cmd_outer | output | 1 | 0 = inner decoder, 1 = outer decoder |
| win_base | output | BW | Index of the first block in the window |
| rel_valid | output | 1 | Release strobe for a block leaving the window |
| rel_blk | output | BW | Index of the released block |
| step_bits | output | SBW | Window jump distance in bits |
| cfg_err | output | 1 | Last start was refused |

## Verification
The assertions check on every cycle that a stalled command holds its index and type, that commands and releases never overlap, that release indices climb by one, that the window base moves only at the end of a release run, and that a refused configuration issues nothing. Only the bench scenarios can show the full order of inner and outer passes, the number of iterations per position, the size of each jump for several window sizes, the value of step_bits, and that a start pulse during a run is ignored. Each of these is compared event by event against a schedule the bench builds from W and Ieff.

// File: rtl/jw_pkg.sv
package jw_pkg;
    localparam int WREF     = 4;
    localparam int WREF_LOG = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_REL  = 2'd2
    } sched_st_e;

    typedef enum logic {
        PH_INNER = 1'b0,
        PH_OUTER = 1'b1
    } phase_e;
endpackage

// File: rtl/jw_cfg_check.sv
module jw_cfg_check #(
    parameter int WW   = 9,
    parameter int IW   = 8,
    parameter int WMAX = 128
) (
    input  logic [WW-1:0] win,
    input  logic [IW-1:0] ieff,
    output logic          ok,
    output logic [IW-1:0] iters,
    output logic [WW-1:0] step_blocks
);
    logic win_pow2, win_min, win_max, ieff_ok;

    always_comb begin
        win_pow2    = (win != '0) && ((win & (win - 1'b1)) == '0);
        win_min     = win >= WW'(jw_pkg::WREF);
        win_max     = win <= WW'(WMAX);
        ieff_ok     = (ieff[jw_pkg::WREF_LOG-1:0] == '0) && (ieff != '0);
        ok          = win_pow2 && win_min && win_max && ieff_ok;
        iters       = ieff >> jw_pkg::WREF_LOG;
        step_blocks = win >> jw_pkg::WREF_LOG;
    end
endmodule

// File: rtl/jw_cmd_seq.sv
module jw_cmd_seq #(
    parameter int WW = 9,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          fire,
    input  logic [WW-1:0] off_last,
    input  logic [IW-1:0] iter_last,
    output logic [WW-1:0] off,
    output jw_pkg::phase_e phase,
    output logic          pos_done
);
    logic [IW-1:0] iter;
    logic          off_end;

    assign off_end  = (off == off_last);
    assign pos_done = fire && off_end && (phase == jw_pkg::PH_OUTER) && (iter == iter_last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            off   <= '0;
            phase <= jw_pkg::PH_INNER;
            iter  <= '0;
        end else if (fire) begin
            if (off_end) begin
                off <= '0;
                if (phase == jw_pkg::PH_OUTER) begin
                    phase <= jw_pkg::PH_INNER;
                    iter  <= (iter == iter_last) ? '0 : iter + 1'b1;
                end else begin
                    phase <= jw_pkg::PH_OUTER;
                end
            end else begin
                off <= off + 1'b1;
            end
        end
    end
endmodule

// File: rtl/jw_rel_seq.sv
module jw_rel_seq #(
    parameter int WW = 9,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          active,
    input  logic [WW-1:0] step_last,
    output logic [BW-1:0] base,
    output logic [BW-1:0] rel_blk,
    output logic          rel_end
);
    logic [WW-1:0] rcnt;

    assign rel_end = active && (rcnt == step_last);
    assign rel_blk = base + BW'(rcnt);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rcnt <= '0;
            base <= '0;
        end else if (active) begin
            if (rcnt == step_last) begin
                rcnt <= '0;
                base <= base + BW'(step_last) + 1'b1;
            end else begin
                rcnt <= rcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/jw_sched.sv
module jw_sched #(
    parameter int WMAX = 128,
    parameter int BW   = 16,
    parameter int KW   = 12,
    parameter int IW   = 8,
    localparam int WW  = $clog2(WMAX) + 2,
    localparam int SBW = KW + WW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [WW-1:0]  cfg_win,
    input  logic [KW-1:0]  cfg_blklen,
    input  logic [IW-1:0]  cfg_ieff,
    output logic           cmd_valid,
    input  logic           cmd_ready,
    output logic [BW-1:0]  cmd_blk,
    output logic           cmd_outer,
    output logic [BW-1:0]  win_base,
    output logic           rel_valid,
    output logic [BW-1:0]  rel_blk,
    output logic [SBW-1:0] step_bits,
    output logic           cfg_err
);
    import jw_pkg::*;

    sched_st_e     st;
    logic [WW-1:0] off_last_r, step_last_r;
    logic [IW-1:0] iter_last_r;
    logic          cfg_ok, load, fire, pos_done, rel_end;
    logic [IW-1:0] cfg_iters;
    logic [WW-1:0] cfg_step;
    logic [WW-1:0] off;
    phase_e        phase;

    jw_cfg_check #(.WW(WW), .IW(IW), .WMAX(WMAX)) u_cfg (
        .win(cfg_win), .ieff(cfg_ieff), .ok(cfg_ok),
        .iters(cfg_iters), .step_blocks(cfg_step)
    );

    assign load      = start && (st == ST_IDLE) && cfg_ok;
    assign cmd_valid = (st == ST_RUN);
    assign rel_valid = (st == ST_REL);
    assign fire      = cmd_valid && cmd_ready;

    jw_cmd_seq #(.WW(WW), .IW(IW)) u_cmd (
        .clk(clk), .rst(rst), .clear(load), .fire(fire),
        .off_last(off_last_r), .iter_last(iter_last_r),
        .off(off), .phase(phase), .pos_done(pos_done)
    );

    jw_rel_seq #(.WW(WW), .BW(BW)) u_rel (
        .clk(clk), .rst(rst), .clear(load), .active(rel_valid),
        .step_last(step_last_r), .base(win_base),
        .rel_blk(rel_blk), .rel_end(rel_end)
    );

    assign cmd_blk   = win_base + BW'(off);
    assign cmd_outer = (phase == PH_OUTER);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            off_last_r  <= '0;
            step_last_r <= '0;
            iter_last_r <= '0;
            step_bits   <= '0;
            cfg_err     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            off_last_r  <= cfg_win - 1'b1;
                            step_last_r <= cfg_step - 1'b1;
                            iter_last_r <= cfg_iters - 1'b1;
                            step_bits   <= SBW'(cfg_step) * SBW'(cfg_blklen);
                            cfg_err     <= 1'b0;
                            st          <= ST_RUN;
                        end else begin
                            cfg_err <= 1'b1;
                        end
                    end
                end
                ST_RUN: if (pos_done) st <= ST_REL;
                ST_REL: if (rel_end)  st <= ST_RUN;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/jw_sched_chk.sv
module jw_sched_chk #(
    parameter int BW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [BW-1:0] cmd_blk,
    input logic          cmd_outer,
    input logic [BW-1:0] win_base,
    input logic          rel_valid,
    input logic [BW-1:0] rel_blk,
    input logic          cfg_err
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_blk) && $stable(cmd_outer)));

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> !cmd_valid);

    // R5
    rel_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && $past(rel_valid)) |-> ((rel_blk - $past(rel_blk)) == BW'(1)));

    // R6
    base_move_chk: assert property (@(posedge clk) disable iff (rst)
        (win_base != $past(win_base)) |-> ($past(rel_valid) && !rel_valid));

    // R2
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !cmd_valid);
endmodule

bind jw_sched jw_sched_chk #(.BW(BW)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_blk(cmd_blk), .cmd_outer(cmd_outer), .win_base(win_base),
    .rel_valid(rel_valid), .rel_blk(rel_blk), .cfg_err(cfg_err)
);

// File: tb/tb_jw_sched.sv
module tb_jw_sched;
    localparam int WMAX = 128;
    localparam int BW   = 16;
    localparam int KW   = 12;
    localparam int IW   = 8;
    localparam int WW   = $clog2(WMAX) + 2;
    localparam int SBW  = KW + WW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [WW-1:0]  cfg_win = '0;
    logic [KW-1:0]  cfg_blklen = '0;
    logic [IW-1:0]  cfg_ieff = '0;
    logic           cmd_valid, cmd_outer, rel_valid, cfg_err;
    logic           cmd_ready = 1'b0;
    logic [BW-1:0]  cmd_blk, win_base, rel_blk;
    logic [SBW-1:0] step_bits;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    jw_sched #(.WMAX(WMAX), .BW(BW), .KW(KW), .IW(IW)) dut (
        .clk(clk), .rst(rst), .start(start), .cfg_win(cfg_win),
        .cfg_blklen(cfg_blklen), .cfg_ieff(cfg_ieff),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_blk(cmd_blk),
        .cmd_outer(cmd_outer), .win_base(win_base), .rel_valid(rel_valid),
        .rel_blk(rel_blk), .step_bits(step_bits), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; cmd_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!cmd_valid && !rel_valid, "R1 valid flags", int'({cmd_valid, rel_valid}), 0);
        check(win_base == '0, "R1 win_base", int'(win_base), 0);
        check(!cfg_err, "R1 cfg_err", int'(cfg_err), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Wait for one accepted command and compare it; honours the stall pattern.
    task automatic expect_cmd(input int blk, input int outer, input int base, input int stall);
        bit held = 1'b0;
        int held_blk = 0;
        for (int t = 0; t < 64; t++) begin
            cmd_ready = (stall != 0) ? ((cyc % 3) == 0) : 1'b1;
            if (held) begin
                // R8: stalled command unchanged
                check(cmd_valid && (int'(cmd_blk) == held_blk), "R8 held command",
                      int'(cmd_blk), held_blk);
                held = 1'b0;
            end
            if (rel_valid) begin
                check(1'b0, "R3/R4 release where a command was due", int'(rel_blk), blk);
                return;
            end
            if (cmd_valid && cmd_ready) begin
                // R3 / R4: block order and decoder type
                check((int'(cmd_blk) == blk) && (int'(cmd_outer) == outer),
                      "R3/R4 command block*2+outer", int'(cmd_blk) * 2 + int'(cmd_outer),
                      blk * 2 + outer);
                check(int'(win_base) == base, "R6 win_base", int'(win_base), base);
                @(negedge clk);
                return;
            end
            if (cmd_valid) begin
                held = 1'b1;
                held_blk = int'(cmd_blk);
            end
            @(negedge clk);
        end
        check(1'b0, "R3 command timeout", 0, blk);
    endtask

    task automatic expect_rel(input int blk);
        // R5: release strobe, ascending, no command alongside
        check(rel_valid && !cmd_valid && (int'(rel_blk) == blk), "R5 release block",
              rel_valid ? int'(rel_blk) : -1, blk);
        @(negedge clk);
    endtask

    task automatic run_sched(input int w, input int k, input int ieff, input int npos,
                             input int stall, input int poke);
        int base = 0;
        int step = w / 4;
        int ipw = ieff / 4;
        do_reset();
        cfg_win = WW'(w); cfg_blklen = KW'(k); cfg_ieff = IW'(ieff);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: jump distance in bits
        check(int'(step_bits) == step * k, "R7 step_bits", int'(step_bits), step * k);
        check(!cfg_err, "R2 legal start err", int'(cfg_err), 0);
        for (int p = 0; p < npos; p++) begin
            for (int it = 0; it < ipw; it++)
                for (int ph = 0; ph < 2; ph++)
                    for (int b = 0; b < w; b++) begin
                        if (poke != 0 && p == 1 && it == 0 && ph == 0 && b == 0) begin
                            start = 1'b1; cfg_win = WW'(3); cfg_ieff = IW'(5);
                        end
                        expect_cmd((base + b) % (1 << BW), ph, base, stall);
                        start = 1'b0; cfg_win = WW'(w); cfg_ieff = IW'(ieff);
                    end
            for (int r = 0; r < step; r++) expect_rel((base + r) % (1 << BW));
            base = base + step;
        end
        // R6: next position starts at once at the jumped base
        check(cmd_valid && int'(win_base) == base, "R6 base after jump", int'(win_base), base);
        if (poke != 0) begin
            // R9: start during run ignored
            check(!cfg_err, "R9 cfg_err after ignored start", int'(cfg_err), 0);
            check(int'(step_bits) == step * k, "R9 step_bits kept", int'(step_bits), step * k);
        end
    endtask

    task automatic bad_cfg(input int w, input int ieff, input string what);
        do_reset();
        cfg_win = WW'(w); cfg_ieff = IW'(ieff); cfg_blklen = KW'(64);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_ready = 1'b1;
        // R2: refused configuration
        check(cfg_err, {"R2 err flag ", what}, int'(cfg_err), 1);
        repeat (3) @(negedge clk);
        check(!cmd_valid && cfg_err, {"R2 no command ", what}, int'(cmd_valid), 0);
    endtask

    task automatic err_then_good();
        bad_cfg(6, 8, "then legal");
        cfg_win = WW'(4); cfg_ieff = IW'(8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: legal start clears the flag
        check(!cfg_err && cmd_valid, "R2 cleared by legal start", int'(cfg_err), 0);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_sched(4, 256, 8, 3, 0, 0);    // classical case, one-block jump
        run_sched(8, 128, 16, 3, 1, 0);   // stalls, two-block jump
        run_sched(16, 64, 12, 2, 0, 0);   // three iterations, four-block jump
        run_sched(32, 32, 4, 2, 0, 1);    // start poked mid-run
        bad_cfg(6, 8, "W=6");
        bad_cfg(2, 8, "W=2");
        bad_cfg(256, 8, "W=256");
        bad_cfg(8, 10, "Ieff=10");
        bad_cfg(8, 0, "Ieff=0");
        err_then_good();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule